// File: doc/BRIEF.md
# Register Write Batch Encoder

This block turns a stream of register write requests into a packed instruction image. Each request carries a 20-bit register offset and a 32-bit data word. The image is held in a local dword buffer that a fetch engine reads through a synchronous read port. A request is stored as a two-dword direct write unless the requester asks for indexed mode. In indexed mode, consecutive writes to the same register are folded into one instruction: a count dword, a header dword, then the data words.

When the batch is complete, the requester strobes commit. The block clears the buffer from the last used dword up to the next 64-byte line boundary and reports the tail length in bytes. It then rewinds its write pointer and its instruction-start pointer. If a request does not fit in the buffer, it is discarded and a sticky overflow flag is raised. A commit that finds the buffer empty is ignored.

Top module: `wr_batch_packer`

## Requirements
- R1: After reset, req_ready and cmt_ready are 1, overflow is 0 and cmt_done is 0.
- R2: A direct request (req_indexed = 0) writes the data at the write pointer and the header at the next dword. The header has bits 31:24 = 0x01, bits 23:20 = 0xF and bits 19:0 = offset. The write pointer advances by 2, and req_ready is low for 1 cycle after acceptance.
- R3: An indexed request that opens a new instruction first rounds the write pointer up to an even dword. It then writes, in order: a count of 1, a header (bits 31:24 = 0x09, bits 23:20 = 0, bits 19:0 = offset) and the data. The dword after the data is zero. req_ready is low for 3 cycles.
- R4: An indexed request whose offset equals the offset of the open indexed instruction appends only its data word and raises that instruction's count dword by one.
- R5: A direct write closes any open indexed instruction. A later indexed request to the same offset therefore opens a new instruction, and so does any indexed request to a different offset.
- R6: After an indexed append, if the write pointer is odd, the dword at the write pointer reads as zero.
- R7: A request whose dwords would not all fit in the DEPTH-dword buffer is dropped, leaving the buffer unchanged and req_ready high. overflow is then set and stays set.
- R8: A commit on a non-empty buffer zeroes every dword from the write pointer up to the next multiple of 16 dwords. It then pulses cmt_done for one cycle, with tail_bytes equal to 4 × write pointer rounded up to a multiple of 64.
- R9: A commit on an empty buffer produces no cmt_done pulse and leaves tail_bytes unchanged.
- R10: A completed commit clears overflow and rewinds the buffer. The next request is placed at dword 0 and never merges with an instruction from before the commit.
- R11: While cmt_valid is high, req_ready is low. A commit accepted together with a pending request is executed first, and that request's data is not written into the committed batch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_indexed | input | 1 | 1 = indexed (mergeable) write, 0 = direct write |
| req_off | input | 20 | Register offset |
| req_data | input | 32 | Register data |
| cmt_valid | input | 1 | Commit request |
| cmt_ready | output | 1 | Commit accepted on this edge when valid |
| cmt_done | output | 1 | One-cycle pulse when a commit finishes |
| tail_bytes | output | $clog2(DEPTH)+3 | Committed length in bytes, line aligned |
| overflow | output | 1 | Sticky: a request was dropped |
| rd_addr | input | $clog2(DEPTH) | Fetch read address (dwords) |
| rd_data | output | 32 | Buffer dword, one cycle after rd_addr |

## Verification
Most internal faults in this block surface as a wrong dword in the buffer. A stale open-instruction record shows up as a count that fails to grow, or as a count written over data. Both are visible on the read port as soon as the request's last write cycle has passed. A misaligned write pointer shifts every later dword, and this also shows up in the next committed tail_bytes. A pointer that fails to rewind shows up in the first request after a commit, which would then not land at dword 0. Overflow bookkeeping errors show up immediately on the overflow port and on the dwords at the top of the buffer.

// File: rtl/wr_batch_packer.sv
module wr_batch_packer #(
  parameter int DEPTH   = 64,
  parameter int LINE_DW = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_indexed,
  input  logic [19:0]                req_off,
  input  logic [31:0]                req_data,
  input  logic                       cmt_valid,
  output logic                       cmt_ready,
  output logic                       cmt_done,
  output logic [$clog2(DEPTH)+2:0]   tail_bytes,
  output logic                       overflow,
  input  logic [$clog2(DEPTH)-1:0]   rd_addr,
  output logic [31:0]                rd_data
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] LMASK  = PW'(LINE_DW - 1);
  localparam logic [PW-1:0] LIM_D  = PW'(DEPTH - 2);
  localparam logic [PW-1:0] LIM_I  = PW'(DEPTH - 3);
  localparam logic [PW-1:0] LIM_M  = PW'(DEPTH - 1);

  typedef enum logic [2:0] {S_IDLE, S_DHDR, S_IHDR, S_DATA, S_CNT, S_PAD, S_FILL} st_t;

  st_t st;
  logic [31:0]   mem [DEPTH];
  logic [PW-1:0] wp, ins, cnt, tail_q;
  logic [19:0]   off_q, open_off;
  logic [31:0]   data_q;
  logic          open_vld;
  logic          we;
  logic [PW-1:0] wa;
  logic [31:0]   wd;

  assign req_ready = (st == S_IDLE) && !cmt_valid;
  assign cmt_ready = (st == S_IDLE);

  wire           take   = req_valid && req_ready;
  wire [PW-1:0]  wp_al  = wp + {{AW{1'b0}}, wp[0]};
  wire           merge  = req_indexed && open_vld && (req_off == open_off);
  wire           fits   = !req_indexed ? (wp <= LIM_D) :
                          merge        ? (wp <= LIM_M) : (wp_al <= LIM_I);
  wire [PW-1:0]  tail_c = (wp + LMASK) & ~LMASK;

  always_comb begin
    we = 1'b0;
    wa = wp;
    wd = '0;
    unique case (st)
      S_IDLE: if (take && fits) begin
        we = 1'b1;
        if (req_indexed && !merge) begin
          wa = wp_al;
          wd = 32'd1;
        end else begin
          wd = req_data;
        end
      end
      S_DHDR: begin we = 1'b1; wd = {8'h01, 4'hF, off_q}; end
      S_IHDR: begin we = 1'b1; wd = {8'h09, 4'h0, off_q}; end
      S_DATA: begin we = 1'b1; wd = data_q; end
      S_CNT:  begin we = 1'b1; wa = ins; wd = {{(32-PW){1'b0}}, cnt}; end
      S_PAD:  we = 1'b1;
      S_FILL: we = (wp != tail_q);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (we) mem[wa[AW-1:0]] <= wd;
    rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      wp         <= '0;
      ins        <= '0;
      cnt        <= '0;
      tail_q     <= '0;
      off_q      <= '0;
      open_off   <= '0;
      data_q     <= '0;
      open_vld   <= 1'b0;
      overflow   <= 1'b0;
      cmt_done   <= 1'b0;
      tail_bytes <= '0;
    end else begin
      cmt_done <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (cmt_valid) begin
            if (wp != '0) begin
              tail_q <= tail_c;
              st     <= S_FILL;
            end
          end else if (req_valid) begin
            off_q  <= req_off;
            data_q <= req_data;
            if (!fits) begin
              overflow <= 1'b1;
            end else if (!req_indexed) begin
              ins      <= wp;
              wp       <= wp + 1'b1;
              open_vld <= 1'b0;
              st       <= S_DHDR;
            end else if (merge) begin
              wp  <= wp + 1'b1;
              cnt <= cnt + 1'b1;
              st  <= S_CNT;
            end else begin
              ins      <= wp_al;
              wp       <= wp_al + 1'b1;
              cnt      <= PW'(1);
              open_vld <= 1'b1;
              open_off <= req_off;
              st       <= S_IHDR;
            end
          end
        end
        S_DHDR: begin wp <= wp + 1'b1; st <= S_IDLE; end
        S_IHDR: begin wp <= wp + 1'b1; st <= S_DATA; end
        S_DATA: begin
          wp <= wp + 1'b1;
          st <= wp[0] ? S_IDLE : S_PAD;
        end
        S_CNT:  st <= wp[0] ? S_PAD : S_IDLE;
        S_PAD:  st <= S_IDLE;
        S_FILL: begin
          if (wp != tail_q) begin
            wp <= wp + 1'b1;
          end else begin
            wp         <= '0;
            ins        <= '0;
            open_vld   <= 1'b0;
            overflow   <= 1'b0;
            cmt_done   <= 1'b1;
            tail_bytes <= {tail_q, 2'b00};
            st         <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wr_batch_packer_chk.sv
module wr_batch_packer_chk #(
  parameter int DEPTH   = 64,
  parameter int LINE_DW = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic                     req_ready,
  input logic                     cmt_ready,
  input logic                     cmt_done,
  input logic                     overflow,
  input logic [$clog2(DEPTH)+2:0] tail_bytes
);
  localparam int LB = $clog2(LINE_DW * 4);

  p_busy_after_take_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !overflow) |=> (!req_ready || overflow));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_done |=> !cmt_done);

  p_tail_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_done |-> (tail_bytes[LB-1:0] == '0 && tail_bytes != '0));

  p_idle_at_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_done |-> cmt_ready);

  p_ovf_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(overflow) |-> cmt_done);
endmodule

bind wr_batch_packer wr_batch_packer_chk #(.DEPTH(DEPTH), .LINE_DW(LINE_DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .cmt_ready(cmt_ready), .cmt_done(cmt_done), .overflow(overflow),
  .tail_bytes(tail_bytes)
);

// File: tb/sim_wr_batch_packer.sv
module sim_wr_batch_packer;
  localparam int DEPTH = 64;
  localparam int AW = $clog2(DEPTH);

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_indexed = 0, cmt_valid = 0;
  logic [19:0] req_off = '0;
  logic [31:0] req_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic req_ready, cmt_ready, cmt_done, overflow;
  logic [AW+2:0] tail_bytes;
  logic [31:0] rd_data;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  wr_batch_packer #(.DEPTH(DEPTH), .LINE_DW(16)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_indexed(req_indexed), .req_off(req_off), .req_data(req_data),
    .cmt_valid(cmt_valid), .cmt_ready(cmt_ready), .cmt_done(cmt_done),
    .tail_bytes(tail_bytes), .overflow(overflow), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [31:0] hd(input logic [19:0] o);
    return {8'h01, 4'hF, o};
  endfunction
  function automatic logic [31:0] hi(input logic [19:0] o);
    return {8'h09, 4'h0, o};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rdchk(input string tag, input int a, input logic [31:0] exp);
    @(negedge clk); rd_addr = AW'(a);
    @(negedge clk); chk(tag, rd_data, exp);
  endtask

  task automatic send(input logic ind, input logic [19:0] o, input logic [31:0] d, output int busy);
    @(negedge clk);
    req_valid = 1; req_indexed = ind; req_off = o; req_data = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    busy = 0;
    while (!req_ready) begin busy++; @(negedge clk); end
  endtask

  task automatic commit(output logic seen, output int tb);
    @(negedge clk);
    cmt_valid = 1;
    while (!cmt_ready) @(negedge clk);
    @(negedge clk);
    cmt_valid = 0;
    while (!cmt_ready) @(negedge clk);
    seen = cmt_done;
    tb = int'(tail_bytes);
  endtask

  task automatic t_reset();
    chk("R1 req_ready", 32'(req_ready), 1);
    chk("R1 cmt_ready", 32'(cmt_ready), 1);
    chk("R1 overflow", 32'(overflow), 0);
    chk("R1 cmt_done", 32'(cmt_done), 0);
  endtask

  task automatic t_direct();
    int b;
    send(0, 20'h12345, 32'hA0A0_0001, b);
    chk("R2 busy", 32'(b), 1);
    rdchk("R2 data", 0, 32'hA0A0_0001);
    rdchk("R2 header", 1, hd(20'h12345));
  endtask

  task automatic t_indexed();
    int b;
    send(1, 20'h00ABC, 32'h1111_0000, b);
    chk("R3 busy", 32'(b), 3);
    rdchk("R3 count", 2, 1);
    rdchk("R3 header", 3, hi(20'h00ABC));
    rdchk("R3 data", 4, 32'h1111_0000);
    rdchk("R6 pad", 5, 0);
    send(1, 20'h00ABC, 32'h2222_0000, b);
    chk("R4 busy even", 32'(b), 1);
    rdchk("R4 appended", 5, 32'h2222_0000);
    rdchk("R4 count 2", 2, 2);
    send(1, 20'h00ABC, 32'h3333_0000, b);
    chk("R6 busy odd", 32'(b), 2);
    rdchk("R4 count 3", 2, 3);
    rdchk("R6 pad after merge", 7, 0);
  endtask

  task automatic t_new_instr();
    int b;
    send(1, 20'h00DEF, 32'h4444_0000, b);
    rdchk("R3 aligned count", 8, 1);
    rdchk("R3 aligned header", 9, hi(20'h00DEF));
    rdchk("R3 gap kept", 7, 0);
    rdchk("R4 old count kept", 2, 3);
    send(0, 20'h00555, 32'h5555_0000, b);
    rdchk("R2 odd start", 11, 32'h5555_0000);
    rdchk("R2 odd header", 12, hd(20'h00555));
    send(1, 20'h00555, 32'h6666_0000, b);
    rdchk("R5 new after direct", 14, 1);
    rdchk("R5 header", 15, hi(20'h00555));
    rdchk("R5 direct hdr intact", 12, hd(20'h00555));
  endtask

  task automatic t_commit();
    logic s; int tb, b;
    commit(s, tb);
    chk("R8 done", 32'(s), 1);
    chk("R8 tail", 32'(tb), 128);
    rdchk("R8 data kept", 16, 32'h6666_0000);
    rdchk("R8 zero 17", 17, 0);
    rdchk("R8 zero 24", 24, 0);
    rdchk("R8 zero 31", 31, 0);
    send(1, 20'h00555, 32'h7777_0000, b);
    rdchk("R10 restart count", 0, 1);
    rdchk("R10 restart header", 1, hi(20'h00555));
  endtask

  task automatic t_empty();
    logic s; int tb;
    commit(s, tb);
    chk("R8 done small", 32'(s), 1);
    chk("R8 tail small", 32'(tb), 64);
    commit(s, tb);
    chk("R9 no done", 32'(s), 0);
    chk("R9 tail held", 32'(tb), 64);
  endtask

  task automatic t_overflow();
    int b; logic s; int tb;
    for (int i = 0; i < 31; i++) send(0, 20'(i), 32'(32'h100 + i), b);
    send(1, 20'h00999, 32'hBAD0_0001, b);
    chk("R7 drop busy", 32'(b), 0);
    chk("R7 flag", 32'(overflow), 1);
    rdchk("R7 last kept", 61, hd(20'd30));
    send(0, 20'h00777, 32'hCAFE_0000, b);
    chk("R7 exact fit busy", 32'(b), 1);
    rdchk("R7 fit data", 62, 32'hCAFE_0000);
    send(0, 20'h00888, 32'hBAD0_0002, b);
    rdchk("R7 top kept", 63, hd(20'h00777));
    rdchk("R7 fit data kept", 62, 32'hCAFE_0000);
    chk("R7 sticky", 32'(overflow), 1);
    commit(s, tb);
    chk("R8 full tail", 32'(tb), 256);
    chk("R10 overflow cleared", 32'(overflow), 0);
  endtask

  task automatic t_collide();
    int b; logic s;
    send(0, 20'h00321, 32'hD00D_0000, b);
    @(negedge clk);
    req_valid = 1; req_indexed = 0; req_off = 20'h00AAA; req_data = 32'hBEEF_0000;
    cmt_valid = 1;
    #1;
    chk("R11 ready low on commit", 32'(req_ready), 0);
    @(negedge clk);
    req_valid = 0; cmt_valid = 0;
    while (!cmt_ready) @(negedge clk);
    s = cmt_done;
    chk("R11 commit ran", 32'(s), 1);
    rdchk("R11 req not written", 0, 32'hD00D_0000);
    rdchk("R11 zero after", 2, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_direct();
    t_indexed();
    t_new_instr();
    t_commit();
    t_empty();
    t_overflow();
    t_collide();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule